// File: doc/BRIEF.md
# Buck Regulator Operating-Mode Sequencer

This block is the digital supervisor of a dual-mode step-down regulator. It watches six comparator flags that come from the analog side: the supply is high enough to start, the supply has sagged into brown-out, the output sits below its nominal level, the output has reached the top of the light-load band, the output has dropped to the bottom of that band, and the inductor current has fallen to zero or below. From these flags it decides which of five operating modes the regulator is in. It then drives a mode code, a sleep enable, a gate enable for the power switches, and a coded current-limit setting.

After power-up, the sequencer brings the regulator up through a soft start. During the soft start the current limit rises in three timed steps. The regulator then runs in fixed-frequency PWM. When the inductor current goes discontinuous, it drops into pulse-frequency (PFM) operation. In PFM it parks in sleep while the output is above the band and resumes when the output falls to the bottom of the band. It goes back to PWM whenever the output is pulled below nominal. A supply brown-out forces it off from any mode. A fresh start is made only once the supply has recovered.

Every flag passes through a two-flop synchroniser before the decision logic sees it. The soft-start step length is a parameter worked out from the clock frequency.

Top module: `buckmode_ctrl`

## Requirements
- R1: After reset the outputs show mode code 0 (power-off), limit code 0, sleep low and gate enable low.
- R2: Power-off moves to soft-start (mode 1) only when the start-threshold flag and the below-nominal flag are both high. In every other case it stays in power-off, and no other mode enters soft-start.
- R3: In soft-start the limit code is 1, then 2, then 3, one for each step. Each code holds for exactly STEP_CYC = CLK_KHZ*STEP_US/1000 cycles. After 3*STEP_CYC cycles in soft-start the mode becomes PWM (mode 2).
- R4: Soft-start ends early and moves to PWM as soon as the below-nominal flag is low.
- R5: PWM moves to PFM (mode 3) when the inductor-zero flag is high and otherwise stays in PWM. In PWM, PFM and sleep the limit code is 4, the full-load setting.
- R6: PFM moves to sleep (mode 4) when the upper-band flag is high. Sleep moves back to PFM when the lower-band flag is high.
- R7: From PFM or sleep the mode goes to PWM when the below-nominal flag is high. This takes precedence over both band flags.
- R8: A high brown-out flag sends every mode to power-off and holds it there, whatever the other flags show.
- R9: Sleep enable is high only in sleep. Gate enable is low in power-off and in sleep and high in every other mode.
- R10: A change on any flag reaches the outputs on the third rising clock edge after it is applied: two synchroniser stages, then the mode register.
- R11: Every entry into soft-start restarts the step timer, so a soft-start cut short by brown-out begins again at limit code 1 with a full step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_ok_i | input | 1 | Supply above start threshold |
| vin_low_i | input | 1 | Supply below brown-out threshold |
| vout_below_nom_i | input | 1 | Output below nominal level |
| vout_above_hi_i | input | 1 | Output at or above upper band |
| vout_below_lo_i | input | 1 | Output at or below lower band |
| il_zero_i | input | 1 | Inductor current at or below zero |
| mode_o | output | 3 | Mode: 0 off, 1 soft-start, 2 PWM, 3 PFM, 4 sleep |
| ilim_o | output | 3 | Current-limit code: 0 none, 1..3 soft steps, 4 full load |
| sleep_o | output | 1 | Sleep enable |
| gate_en_o | output | 1 | Power-switch gate enable |

## Verification
The bench drives the soft-start ramp cycle by cycle at each step boundary. A timer that is off by one would show a code change one cycle early or late, and one that is not rearmed would resume at code 2 or 3 after a brown-out. Contested flags are held together: brown-out alongside a valid start condition, and below-nominal alongside both band flags. A priority slip then appears as a wrong mode, for example sleep where PWM belongs. A flag change is sampled on each side of the third edge, so a missing or extra synchroniser stage shows up as a one-cycle shift. Random flag patterns held for a few cycles each are checked every cycle against a model built from the requirements.

// File: rtl/buckmode_pkg.sv
package buckmode_pkg;

    typedef enum logic [2:0] {
        MODE_OFF   = 3'd0,
        MODE_SOFT  = 3'd1,
        MODE_PWM   = 3'd2,
        MODE_PFM   = 3'd3,
        MODE_SLEEP = 3'd4
    } mode_e;

    localparam int SOFT_STEPS = 3;
    localparam int STEP_IDX_W = $clog2(SOFT_STEPS);
    localparam int LIM_W      = 3;
    localparam logic [LIM_W-1:0] LIM_NONE = 3'd0;
    localparam logic [LIM_W-1:0] LIM_FULL = 3'd4;

    typedef struct packed {
        logic vin_ok;
        logic vin_low;
        logic below_nom;
        logic above_hi;
        logic below_lo;
        logic il_zero;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

    // Mode decision; brown-out is tested first so it outranks every other path.
    function automatic mode_e pick_mode(mode_e cur, flags_t f, logic ramp_done);
        mode_e nxt;
        nxt = cur;
        if (f.vin_low) begin
            nxt = MODE_OFF;
        end else begin
            unique case (cur)
                MODE_OFF:   if (f.vin_ok && f.below_nom) nxt = MODE_SOFT;
                MODE_SOFT:  if (ramp_done || !f.below_nom) nxt = MODE_PWM;
                MODE_PWM:   if (f.il_zero) nxt = MODE_PFM;
                MODE_PFM: begin
                    if (f.below_nom)     nxt = MODE_PWM;
                    else if (f.above_hi) nxt = MODE_SLEEP;
                end
                MODE_SLEEP: begin
                    if (f.below_nom)     nxt = MODE_PWM;
                    else if (f.below_lo) nxt = MODE_PFM;
                end
                default:    nxt = MODE_OFF;
            endcase
        end
        return nxt;
    endfunction

    function automatic logic [LIM_W-1:0] soft_limit(logic [STEP_IDX_W-1:0] step);
        return LIM_W'(step) + LIM_W'(1);
    endfunction

endpackage

// File: rtl/buckmode_sync.sv
module buckmode_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= d_i;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/buckmode_steptimer.sv
module buckmode_steptimer
    import buckmode_pkg::*;
#(
    parameter int STEP_CYC = 31250
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  run_i,
    output logic [STEP_IDX_W-1:0] step_o,
    output logic                  done_o
);
    localparam int CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_CYC - 1);
    localparam logic [STEP_IDX_W-1:0] STEP_LAST = STEP_IDX_W'(SOFT_STEPS - 1);

    logic [CNT_W-1:0]      cnt_q;
    logic [STEP_IDX_W-1:0] step_q;
    logic                  at_end;

    assign at_end = (cnt_q == CNT_LAST);

    // Held cleared outside soft-start, so each entry starts from step 0.
    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q  <= '0;
            step_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
            if (step_q != STEP_LAST) step_q <= step_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign step_o = step_q;
    assign done_o = run_i && at_end && (step_q == STEP_LAST);
endmodule

// File: rtl/buckmode_fsm.sv
module buckmode_fsm
    import buckmode_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  flags_t flags_i,
    input  logic   ramp_done_i,
    output mode_e  mode_o
);
    mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_OFF;
        else     mode_q <= pick_mode(mode_q, flags_i, ramp_done_i);
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/buckmode_ctrl.sv
module buckmode_ctrl
    import buckmode_pkg::*;
#(
    parameter int CLK_KHZ     = 125000,
    parameter int STEP_US     = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vin_ok_i,
    input  logic       vin_low_i,
    input  logic       vout_below_nom_i,
    input  logic       vout_above_hi_i,
    input  logic       vout_below_lo_i,
    input  logic       il_zero_i,
    output logic [2:0] mode_o,
    output logic [2:0] ilim_o,
    output logic       sleep_o,
    output logic       gate_en_o
);
    localparam int STEP_CYC = (CLK_KHZ * STEP_US) / 1000;

    flags_t                raw_flags;
    flags_t                syn_flags;
    logic [FLAG_W-1:0]     syn_bits;
    mode_e                 mode;
    logic [STEP_IDX_W-1:0] step;
    logic                  ramp_done;

    always_comb begin
        raw_flags.vin_ok    = vin_ok_i;
        raw_flags.vin_low   = vin_low_i;
        raw_flags.below_nom = vout_below_nom_i;
        raw_flags.above_hi  = vout_above_hi_i;
        raw_flags.below_lo  = vout_below_lo_i;
        raw_flags.il_zero   = il_zero_i;
    end

    buckmode_sync #(.WIDTH(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_flags),
        .q_o (syn_bits)
    );
    assign syn_flags = flags_t'(syn_bits);

    buckmode_steptimer #(.STEP_CYC(STEP_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (mode == MODE_SOFT),
        .step_o (step),
        .done_o (ramp_done)
    );

    buckmode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .flags_i     (syn_flags),
        .ramp_done_i (ramp_done),
        .mode_o      (mode)
    );

    always_comb begin
        mode_o    = mode;
        sleep_o   = 1'b0;
        gate_en_o = 1'b1;
        ilim_o    = LIM_FULL;
        unique case (mode)
            MODE_OFF: begin
                gate_en_o = 1'b0;
                ilim_o    = LIM_NONE;
            end
            MODE_SOFT:  ilim_o = soft_limit(step);
            MODE_SLEEP: begin
                gate_en_o = 1'b0;
                sleep_o   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/buckmode_chk.sv
module buckmode_chk
    import buckmode_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       vin_low_i,
    input logic [2:0] mode_o,
    input logic [2:0] ilim_o,
    input logic       sleep_o,
    input logic       gate_en_o
);
    AST_SLEEP_ONLY_SLEEP: assert property (@(posedge clk) disable iff (rst)
        sleep_o == (mode_o == MODE_SLEEP)); // R9

    AST_GATES_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_OFF || mode_o == MODE_SLEEP) |-> !gate_en_o); // R9

    AST_SOFT_ONLY_FROM_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_PWM || mode_o == MODE_PFM || mode_o == MODE_SLEEP)
        |=> (mode_o != MODE_SOFT)); // R2

    AST_SOFT_LIMIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_SOFT) |-> (ilim_o >= 3'd1 && ilim_o <= 3'd3)); // R3

    AST_SOFT_LIMIT_RISES: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_SOFT) |=> (mode_o != MODE_SOFT || ilim_o >= $past(ilim_o))); // R3

    AST_RUN_LIMIT_FULL: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_PWM || mode_o == MODE_PFM || mode_o == MODE_SLEEP)
        |-> (ilim_o == LIM_FULL)); // R5

    AST_SLEEP_VIA_PFM: assert property (@(posedge clk) disable iff (rst)
        (mode_o != MODE_PFM && mode_o != MODE_SLEEP) |=> (mode_o != MODE_SLEEP)); // R6

    AST_BROWNOUT_OFF: assert property (@(posedge clk) disable iff (rst)
        (vin_low_i && $past(vin_low_i) && $past(vin_low_i, 2)) |=> (mode_o == MODE_OFF)); // R8
endmodule

bind buckmode_ctrl buckmode_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .vin_low_i (vin_low_i),
    .mode_o    (mode_o),
    .ilim_o    (ilim_o),
    .sleep_o   (sleep_o),
    .gate_en_o (gate_en_o)
);

// File: tb/sim_buckmode_ctrl.sv
module sim_buckmode_ctrl;
    localparam int CLK_KHZ = 125000;
    localparam int STEP_US = 1;
    localparam int STEP    = CLK_KHZ * STEP_US / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ok = 0, low = 0, bn = 0, ah = 0, bl = 0, iz = 0;
    logic [2:0] mode_o, ilim_o;
    logic sleep_o, gate_en_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    buckmode_ctrl #(.CLK_KHZ(CLK_KHZ), .STEP_US(STEP_US)) u0 (
        .clk(clk), .rst(rst),
        .vin_ok_i(ok), .vin_low_i(low), .vout_below_nom_i(bn),
        .vout_above_hi_i(ah), .vout_below_lo_i(bl), .il_zero_i(iz),
        .mode_o(mode_o), .ilim_o(ilim_o), .sleep_o(sleep_o), .gate_en_o(gate_en_o)
    );

    // Reference model written from the requirements (codes: 0 off,1 soft,2 pwm,3 pfm,4 sleep)
    logic [5:0] m_s1, m_s2;
    int m_st, m_cnt, m_step;

    function automatic int ref_next(int st, logic [5:0] f, bit rdone);
        // f = {ok, low, bn, ah, bl, iz}
        if (f[4]) return 0;
        case (st)
            0: return (f[5] && f[3]) ? 1 : 0;
            1: return (rdone || !f[3]) ? 2 : 1;
            2: return f[0] ? 3 : 2;
            3: return f[3] ? 2 : (f[2] ? 4 : 3);
            4: return f[3] ? 2 : (f[1] ? 3 : 4);
            default: return 0;
        endcase
    endfunction

    function automatic int ref_ilim(int st, int step);
        if (st == 0) return 0;
        if (st == 1) return step + 1;
        return 4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_st <= 0; m_cnt <= 0; m_step <= 0;
        end else begin
            m_s1 <= {ok, low, bn, ah, bl, iz};
            m_s2 <= m_s1;
            m_st <= ref_next(m_st, m_s2, (m_st == 1) && (m_step == 2) && (m_cnt == STEP - 1));
            if (m_st != 1) begin
                m_cnt <= 0; m_step <= 0;
            end else if (m_cnt == STEP - 1) begin
                m_cnt <= 0;
                if (m_step < 2) m_step <= m_step + 1;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R10 mode vs model", int'(mode_o), m_st);
            chk("R3 limit vs model", int'(ilim_o), ref_ilim(m_st, m_step));
            chk("R9 sleep vs model", int'(sleep_o), (m_st == 4) ? 1 : 0);
            chk("R9 gate vs model", int'(gate_en_o), (m_st == 0 || m_st == 4) ? 0 : 1);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic setf(logic a, logic b, logic c, logic d, logic e, logic f);
        ok = a; low = b; bn = c; ah = d; bl = e; iz = f;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog: got %0d expected %0d", 0, 1);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(4);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 mode", mode_o, 0); chk("R1 limit", ilim_o, 0);
        chk("R1 sleep", sleep_o, 0); chk("R1 gate", gate_en_o, 0);

        // R2 only the combined start condition leaves power-off
        setf(0, 0, 1, 0, 0, 0); tick(8); chk("R2 no start without supply", mode_o, 0);
        setf(1, 0, 0, 0, 0, 0); tick(8); chk("R2 no start with output high", mode_o, 0);

        // R10 latency, then R3 ramp boundaries
        setf(1, 0, 1, 0, 0, 0);
        tick(2); chk("R10 before third edge", mode_o, 0);
        tick(1); chk("R10 on third edge", mode_o, 1);
        chk("R3 first step", ilim_o, 1);
        tick(STEP - 1); chk("R3 first step end", ilim_o, 1);
        tick(1); chk("R3 second step", ilim_o, 2);
        tick(STEP); chk("R3 third step", ilim_o, 3);
        tick(STEP - 1); chk("R3 last soft cycle", mode_o, 1);
        tick(1); chk("R3 ramp done to PWM", mode_o, 2);
        chk("R5 full limit", ilim_o, 4);

        // R5 / R6 / R7 light-load sequence
        setf(1, 0, 1, 0, 0, 1); tick(3); chk("R5 PWM to PFM", mode_o, 3);
        setf(1, 0, 0, 0, 0, 1); tick(1);
        setf(1, 0, 0, 1, 0, 1); tick(3); chk("R6 PFM to sleep", mode_o, 4);
        chk("R9 sleep high", sleep_o, 1); chk("R9 gate low", gate_en_o, 0);
        setf(1, 0, 0, 0, 1, 1); tick(3); chk("R6 sleep to PFM", mode_o, 3);
        setf(1, 0, 0, 1, 0, 1); tick(3); chk("R6 back to sleep", mode_o, 4);
        setf(1, 0, 1, 1, 1, 0); tick(3); chk("R7 sleep to PWM over bands", mode_o, 2);
        setf(1, 0, 0, 0, 0, 1); tick(3); chk("R5 PWM to PFM again", mode_o, 3);
        setf(1, 0, 1, 1, 0, 0); tick(3); chk("R7 PFM to PWM over upper band", mode_o, 2);

        // R8 brown-out with start condition present
        setf(1, 1, 1, 0, 0, 0); tick(3); chk("R8 PWM to off", mode_o, 0);
        tick(10); chk("R8 held off", mode_o, 0);
        // R11 interrupted ramp restarts from step one
        setf(1, 0, 1, 0, 0, 0); tick(3); chk("R2 restart soft", mode_o, 1);
        tick(2 * STEP + 5); chk("R3 deep in ramp", ilim_o, 3);
        setf(1, 1, 1, 0, 0, 0); tick(3); chk("R8 soft to off", mode_o, 0);
        setf(1, 0, 1, 0, 0, 0); tick(3); chk("R11 restart limit", ilim_o, 1);
        tick(STEP - 1); chk("R11 full first step", ilim_o, 1);
        // R4 early exit
        tick(10); chk("R3 second step again", ilim_o, 2);
        setf(1, 0, 0, 0, 0, 0); tick(3); chk("R4 early exit", mode_o, 2);
        // R8 from PFM and sleep
        setf(1, 0, 0, 0, 0, 1); tick(3);
        setf(1, 0, 0, 1, 0, 1); tick(3); chk("R6 sleep before brown-out", mode_o, 4);
        setf(1, 1, 0, 1, 0, 1); tick(3); chk("R8 sleep to off", mode_o, 0);

        // Random phase, checked every cycle against the model
        for (int i = 0; i < 2500; i++) begin
            setf(($urandom % 4) != 0, ($urandom % 20) == 0, ($urandom % 3) == 0,
                 ($urandom % 2) == 1, ($urandom % 2) == 1, ($urandom % 3) == 0);
            tick(1 + ($urandom % 6));
        end
        finish_run();
    end
endmodule